// File: doc/BRIEF.md
# Serial Peripheral Link Controller with Shared-Wire Option

This block moves 8-bit words over an SPI link as master or slave. Words enter on a valid/ready transmit stream. Received words leave on a receive stream that is valid-only. A 7-bit rate register sets the serial clock when the block is master. Pin routing sends the serial data either over separate in and out pins or over one shared pin whose driver a direction control turns on or off. The block drives a tri-state enable for each of the four link pins.

As master, the select pin can be left alone, driven as a select output, or watched as a fault input. If another device pulls the watched select low, the block records a fault, drops to slave behaviour and releases every pin driver until software clears the fault. A wait input, combined with a stop-in-wait control bit, freezes the whole engine so no clock edge advances it.

Transmit stream rules: a word is taken on a cycle where both `tx_valid` and `tx_ready` are high. `tx_valid` and `tx_data` must stay stable until then. A master drops `tx_ready` for the whole transfer. A slave holds one word and raises `tx_ready` again only after that word has been shifted out and its select is high. The receive stream has no back-pressure: `rx_valid` is a one-cycle pulse that also marks transfer completion, and the consumer must take `rx_data` in that cycle.

Top module: `spi_link_ctrl`

## Requirements
- R1: The rate register is 0 after reset. A write stores a 3-bit prescale field P (write bits 6:4) and a 4-bit exponent field S (write bits 3:0). The read value returns these in bits 6:0, and bit 7 always reads 0.
- R2: As master, each SCK half period lasts (P+1)·2^S bus clocks, so a full SCK period is (P+1)·2^(S+1) bus clocks.
- R3: A master transfer shifts 8 bits MSB first in each of the four clock polarity/phase settings. It gives exactly one `rx_valid` pulse, on the cycle after the eighth bit is sampled, and SCK rests at the polarity level whenever no transfer runs.
- R4: As master with separate data pins, SCK and MOSI drivers are enabled and the MISO driver is off.
- R5: As master with the shared-wire bit set, data uses only the MOSI pin. Its driver follows the direction bit, received bits come from `mosi_i`, `miso_i` is ignored, and the MISO driver stays off.
- R6: As slave, SCK, SS and MOSI drivers are off. The MISO driver is on only while the synchronised select is low; in shared-wire mode it also requires the direction bit to be 1.
- R7: As master, SS is driven only when the fault-enable bit and the select-drive bit are both 1. Driven SS is low while a transfer runs and high otherwise.
- R8: As master with fault enable set and select-drive clear, a low level on `ss_i` sets `fault_flag` within 4 clocks. While the flag is set, all four drivers are off and `tx_ready` is low. `fault_clr` clears the flag.
- R9: With `wait_mode` and the stop-in-wait bit both 1, the engine holds: SCK stays constant, no word completes and `tx_ready` is low. The transfer resumes intact when either input drops. With the stop-in-wait bit at 0, `wait_mode` has no effect.
- R10: A master accepts a word only on a `tx_valid`/`tx_ready` handshake, and `tx_ready` is low on the cycle after that handshake.
- R11: As slave with clock phase 0, the block shows the loaded word on MISO MSB first, one bit per SCK period, and samples MOSI on each leading edge. It delivers the 8 sampled bits as one word.
- R12: With the enable bit at 0, all drivers are off and `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_mode | input | 1 | Device is in wait state |
| cfg_enable | input | 1 | Block enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_single_wire | input | 1 | Shared-wire data pin mode |
| cfg_dir_out | input | 1 | Shared-pin driver on (shared-wire mode only) |
| cfg_fault_en | input | 1 | Master uses the SS pin |
| cfg_ss_drive | input | 1 | With fault enable: 1 = drive SS, 0 = watch SS for faults |
| cfg_stop_wait | input | 1 | Freeze the engine during wait |
| baud_we | input | 1 | Rate register write strobe |
| baud_wdata | input | 7 | P in bits 6:4, S in bits 3:0 |
| baud_rdata | output | 8 | Rate register read value, bit 7 zero |
| tx_valid | input | 1 | Transmit word valid |
| tx_data | input | 8 | Transmit word |
| tx_ready | output | 1 | Transmit word can be taken |
| rx_valid | output | 1 | Received word pulse / transfer complete |
| rx_data | output | 8 | Received word |
| fault_flag | output | 1 | Mode fault recorded |
| fault_clr | input | 1 | Clear the fault flag |
| sck_i | input | 1 | SCK pin input |
| sck_o | output | 1 | SCK pin output value |
| sck_oe | output | 1 | SCK driver enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output value |
| mosi_oe | output | 1 | MOSI driver enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output value |
| miso_oe | output | 1 | MISO driver enable |
| ss_i | input | 1 | SS pin input |
| ss_o | output | 1 | SS pin output value |
| ss_oe | output | 1 | SS driver enable |

## Verification
The properties assume the configuration pins, and clock polarity in particular, do not change while a transfer is running or while the engine is frozen by wait. They also assume `tx_valid` is held until its handshake. The stimulus changes configuration only between transfers, after SS has returned high or the fault has been cleared. As slave, it drives SCK and select slowly, with at least six bus clocks between changes, so the two-stage input synchroniser never misses an edge. Random master transfers draw data, polarity, phase and small rate values from a seeded generator and loop MOSI back into MISO, so each received word must equal the word sent.

// File: rtl/spi_link_pkg.sv
package spi_link_pkg;
  typedef struct packed {
    logic sck;
    logic mosi;
    logic miso;
    logic ss;
  } pin_en_t;
endpackage

// File: rtl/spi_baud_div.sv
module spi_baud_div #(
  parameter int PRE_W  = 3,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              run,
  input  logic [PRE_W-1:0]  sppr,
  input  logic [RATE_W-1:0] spr,
  output logic              tick
);
  localparam int CNT_W = PRE_W + (1 << RATE_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // half period in bus clocks: (P+1) << S
  assign limit = (CNT_W'(sppr) + CNT_W'(1)) << spr;
  assign tick  = ce && run && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (ce)     cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              is_master,
  input  logic              cpha,
  input  logic              abort,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              clr,
  input  logic              edge_ev,
  input  logic              din,
  output logic              busy,
  output logic              loaded,
  output logic              edge_odd,
  output logic              dout,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  localparam int EDGE_W = $clog2(2 * DATA_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);
  localparam logic [EDGE_W-1:0] LAST_SMP  = EDGE_W'(2 * DATA_W - 2);

  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic lead, do_sample, do_shift;

  // even edge index = leading edge of an SCK period
  assign lead      = ~edge_q[0];
  assign do_sample = cpha ? ~lead : lead;
  assign do_shift  = cpha ? (lead && edge_q != '0) : ~lead;
  assign dout      = tx_sh[DATA_W-1];
  assign edge_odd  = edge_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0; tx_sh <= '0; rx_sh <= '0;
      busy <= 1'b0; loaded <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (ce) begin
        if (abort) begin
          busy <= 1'b0; loaded <= 1'b0; edge_q <= '0;
        end else if (load) begin
          tx_sh <= load_data; loaded <= 1'b1; busy <= is_master; edge_q <= '0;
        end else if (clr) begin
          edge_q <= '0;
        end else if (edge_ev) begin
          edge_q <= edge_q + EDGE_W'(1);
          if (do_sample) begin
            rx_sh <= {rx_sh[DATA_W-2:0], din};
            if (edge_q >= LAST_SMP) begin
              rx_valid <= 1'b1;
              rx_data  <= {rx_sh[DATA_W-2:0], din};
            end
          end
          if (do_shift) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
          if (edge_q == LAST_EDGE) begin
            busy <= 1'b0; loaded <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_pin_route.sv
module spi_pin_route
  import spi_link_pkg::*;
(
  input  logic    enable,
  input  logic    master,
  input  logic    fault,
  input  logic    single,
  input  logic    dir_out,
  input  logic    fault_en,
  input  logic    ss_drive,
  input  logic    ss_low,
  input  logic    mosi_i,
  input  logic    miso_i,
  output pin_en_t oe,
  output logic    din
);
  always_comb begin
    oe = '0;
    if (enable && !fault) begin
      if (master) begin
        oe.sck  = 1'b1;
        oe.mosi = single ? dir_out : 1'b1;
        oe.ss   = fault_en & ss_drive;
      end else begin
        oe.miso = ss_low & (single ? dir_out : 1'b1);
      end
    end
    if (master) din = single ? mosi_i : miso_i;
    else        din = single ? miso_i : mosi_i;
  end
endmodule

// File: rtl/spi_link_ctrl.sv
module spi_link_ctrl
  import spi_link_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_W       = 3,
  parameter int RATE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wait_mode,
  input  logic                    cfg_enable,
  input  logic                    cfg_master,
  input  logic                    cfg_cpol,
  input  logic                    cfg_cpha,
  input  logic                    cfg_single_wire,
  input  logic                    cfg_dir_out,
  input  logic                    cfg_fault_en,
  input  logic                    cfg_ss_drive,
  input  logic                    cfg_stop_wait,
  input  logic                    baud_we,
  input  logic [PRE_W+RATE_W-1:0] baud_wdata,
  output logic [PRE_W+RATE_W:0]   baud_rdata,
  input  logic                    tx_valid,
  input  logic [DATA_W-1:0]       tx_data,
  output logic                    tx_ready,
  output logic                    rx_valid,
  output logic [DATA_W-1:0]       rx_data,
  output logic                    fault_flag,
  input  logic                    fault_clr,
  input  logic                    sck_i,
  output logic                    sck_o,
  output logic                    sck_oe,
  input  logic                    mosi_i,
  output logic                    mosi_o,
  output logic                    mosi_oe,
  input  logic                    miso_i,
  output logic                    miso_o,
  output logic                    miso_oe,
  input  logic                    ss_i,
  output logic                    ss_o,
  output logic                    ss_oe
);
  logic [PRE_W-1:0]       sppr_q;
  logic [RATE_W-1:0]      spr_q;
  logic [SYNC_STAGES-1:0] sck_pipe, ss_pipe;
  logic sck_s, ss_s, sck_prev, ce, is_master, fault_q, fault_set;
  logic tick, busy, loaded, edge_odd, dout, din, load, edge_ev, slave_ev;
  pin_en_t oe;

  assign ce = ~(wait_mode & cfg_stop_wait);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sppr_q <= '0; spr_q <= '0;
    end else if (baud_we) begin
      sppr_q <= baud_wdata[PRE_W+RATE_W-1:RATE_W];
      spr_q  <= baud_wdata[RATE_W-1:0];
    end
  end
  assign baud_rdata = {1'b0, sppr_q, spr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= '0; ss_pipe <= '1; sck_prev <= 1'b0;
    end else begin
      sck_pipe <= {sck_pipe[SYNC_STAGES-2:0], sck_i};
      ss_pipe  <= {ss_pipe[SYNC_STAGES-2:0], ss_i};
      sck_prev <= sck_s;
    end
  end
  assign sck_s = sck_pipe[SYNC_STAGES-1];
  assign ss_s  = ss_pipe[SYNC_STAGES-1];

  assign fault_set = cfg_enable & cfg_master & cfg_fault_en & ~cfg_ss_drive & ~ss_s & ~fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   fault_q <= 1'b0;
    else if (ce) begin
      if (fault_set)      fault_q <= 1'b1;
      else if (fault_clr) fault_q <= 1'b0;
    end
  end
  assign fault_flag = fault_q;
  assign is_master  = cfg_master & ~fault_q;

  assign tx_ready = ce & cfg_enable & ~fault_q &
                    (is_master ? ~busy : (~loaded & ss_s));
  assign load     = tx_valid & tx_ready;
  assign slave_ev = ce & ~is_master & ~ss_s & (sck_s ^ sck_prev);
  assign edge_ev  = is_master ? tick : slave_ev;

  spi_baud_div #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .ce(ce), .run(busy),
    .sppr(sppr_q), .spr(spr_q), .tick(tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .ce(ce), .is_master(is_master), .cpha(cfg_cpha),
    .abort(fault_set | ~cfg_enable), .load(load), .load_data(tx_data),
    .clr(~is_master & ss_s), .edge_ev(edge_ev), .din(din),
    .busy(busy), .loaded(loaded), .edge_odd(edge_odd), .dout(dout),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  spi_pin_route u_route (
    .enable(cfg_enable), .master(cfg_master), .fault(fault_q),
    .single(cfg_single_wire), .dir_out(cfg_dir_out), .fault_en(cfg_fault_en),
    .ss_drive(cfg_ss_drive), .ss_low(~ss_s), .mosi_i(mosi_i), .miso_i(miso_i),
    .oe(oe), .din(din)
  );

  assign sck_o   = cfg_cpol ^ (busy & edge_odd);
  assign ss_o    = ~busy;
  assign mosi_o  = dout;
  assign miso_o  = dout;
  assign sck_oe  = oe.sck;
  assign mosi_oe = oe.mosi;
  assign miso_oe = oe.miso;
  assign ss_oe   = oe.ss;
endmodule

// File: rtl/spi_link_sva.sv
module spi_link_sva (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_master,
  input logic wait_mode,
  input logic cfg_stop_wait,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic sck_o,
  input logic sck_oe,
  input logic mosi_oe,
  input logic miso_oe,
  input logic ss_oe,
  input logic fault_flag
);
  a_r8_fault_releases: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |-> !(sck_oe || mosi_oe || miso_oe || ss_oe || tx_ready));

  a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !(tx_ready || sck_oe || mosi_oe || miso_oe || ss_oe));

  a_r6_slave_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && !cfg_master) |-> !(sck_oe || ss_oe || mosi_oe));

  a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && cfg_master && !fault_flag) |=> !tx_ready);

  a_r9_wait_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mode && cfg_stop_wait && $past(wait_mode && cfg_stop_wait)) |-> $stable(sck_o));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind spi_link_ctrl spi_link_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
  .wait_mode(wait_mode), .cfg_stop_wait(cfg_stop_wait), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .sck_o(sck_o), .sck_oe(sck_oe),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe), .ss_oe(ss_oe), .fault_flag(fault_flag)
);

// File: tb/spi_link_ctrl_tb_top.sv
module spi_link_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_mode = 0, cfg_enable = 0, cfg_master = 0, cfg_cpol = 0, cfg_cpha = 0;
  logic cfg_single_wire = 0, cfg_dir_out = 0, cfg_fault_en = 0, cfg_ss_drive = 0, cfg_stop_wait = 0;
  logic baud_we = 0;
  logic [6:0] baud_wdata = '0;
  logic [7:0] baud_rdata;
  logic tx_valid = 0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, fault_flag;
  logic [7:0] rx_data;
  logic fault_clr = 0;
  logic sck_tb = 0, mosi_tb = 0, miso_tb = 0, ss_tb = 1, loop_en = 0;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe, miso_w;

  int n_chk = 0, n_fail = 0, rx_cnt = 0;
  logic [7:0] last_rx = '0;

  always #10 clk = ~clk;
  assign miso_w = loop_en ? mosi_o : miso_tb;

  spi_link_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode), .cfg_enable(cfg_enable),
    .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_single_wire(cfg_single_wire), .cfg_dir_out(cfg_dir_out),
    .cfg_fault_en(cfg_fault_en), .cfg_ss_drive(cfg_ss_drive), .cfg_stop_wait(cfg_stop_wait),
    .baud_we(baud_we), .baud_wdata(baud_wdata), .baud_rdata(baud_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .fault_flag(fault_flag), .fault_clr(fault_clr),
    .sck_i(sck_tb), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_tb), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_w), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_i(ss_tb), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  always @(posedge clk) if (rst_n && rx_valid) begin rx_cnt++; last_rx = rx_data; end

  function automatic int exp_half(input logic [6:0] b);
    return (int'(b[6:4]) + 1) << b[3:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_baud(input logic [6:0] v);
    @(negedge clk); baud_wdata = v; baud_we = 1;
    @(negedge clk); baud_we = 0;
  endtask

  task automatic send(input logic [7:0] d);
    int t = 0;
    @(negedge clk);
    while (!tx_ready && t < 2000) begin @(negedge clk); t++; end
    tx_data = d; tx_valid = 1;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic wait_rx(input int n0, input string req);
    int t = 0;
    while (rx_cnt == n0 && t < 6000) begin @(negedge clk); t++; end
    chk(rx_cnt == n0 + 1, req, rx_cnt - n0, 1);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (ss_o !== 1'b1 && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic mxfer(input logic [7:0] d, input string req);
    int n0 = rx_cnt;
    send(d);
    wait_rx(n0, req);
    chk(last_rx == d, req, last_rx, d);
    wait_idle();
    chk(sck_o == cfg_cpol, req, sck_o, cfg_cpol);
  endtask

  task automatic measure_half(input logic [6:0] b, input string req);
    int n = 0;
    logic s;
    @(negedge clk); s = sck_o;
    while (sck_o == s && n < 2000) begin @(negedge clk); n++; end
    n = 0; s = sck_o;
    while (sck_o == s && n < 2000) begin @(negedge clk); n++; end
    chk(n == exp_half(b), req, n, exp_half(b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    int n0;
    logic s;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // reset state
    chk(baud_rdata == 8'h00, "R1 reset", baud_rdata, 0);
    chk(!tx_ready && !sck_oe && !mosi_oe && !miso_oe && !ss_oe, "R12 reset quiet", tx_ready, 0);
    chk(fault_flag == 0, "R8 reset", fault_flag, 0);
    rst_n = 1;
    wr_baud(7'h5A); chk(baud_rdata == 8'h5A, "R1 readback", baud_rdata, 8'h5A);
    wr_baud(7'h7F); chk(baud_rdata == 8'h7F, "R1 bit7 zero", baud_rdata, 8'h7F);

    // master, separate pins
    wr_baud(7'h00);
    cfg_enable = 1; cfg_master = 1; loop_en = 1;
    @(negedge clk);
    chk(sck_oe && mosi_oe && !miso_oe, "R4 master drivers", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    chk(!ss_oe, "R7 ss released", ss_oe, 0);
    for (int m = 0; m < 4; m++) begin
      cfg_cpol = m[1]; cfg_cpha = m[0];
      mxfer(8'hA5 ^ 8'(m), "R3 directed mode");
    end
    for (int i = 0; i < 16; i++) begin
      cfg_cpol = 1'($urandom_range(0, 1)); cfg_cpha = 1'($urandom_range(0, 1));
      wr_baud({3'($urandom_range(0, 3)), 4'($urandom_range(0, 2))});
      mxfer(8'($urandom_range(0, 255)), "R3 random");
    end

    // divider and driven SS
    cfg_cpol = 0; cfg_cpha = 0; cfg_fault_en = 1; cfg_ss_drive = 1;
    wr_baud(7'h21);
    n0 = rx_cnt;
    send(8'h3C);
    chk(ss_oe && ss_o == 0, "R7 ss low in transfer", ss_o, 0);
    chk(!tx_ready, "R10 ready low busy", tx_ready, 0);
    measure_half(7'h21, "R2 half P2 S1");
    wait_rx(n0, "R2 complete"); wait_idle();
    chk(ss_o == 1, "R7 ss high idle", ss_o, 1);
    wr_baud(7'h03);
    n0 = rx_cnt; send(8'h81);
    measure_half(7'h03, "R2 half P0 S3");
    wait_rx(n0, "R2 complete"); wait_idle();

    // wait-mode freeze
    wr_baud(7'h02);
    n0 = rx_cnt; send(8'h96);
    repeat (10) @(negedge clk);
    wait_mode = 1; cfg_stop_wait = 1;
    @(negedge clk); s = sck_o;
    repeat (60) @(negedge clk);
    chk(sck_o == s && rx_cnt == n0 && !tx_ready, "R9 frozen", sck_o, s);
    wait_mode = 0;
    wait_rx(n0, "R9 resume");
    chk(last_rx == 8'h96, "R9 resume data", last_rx, 8'h96);
    wait_idle();
    cfg_stop_wait = 0; wait_mode = 1;
    mxfer(8'h5B, "R9 no stop bit");
    wait_mode = 0;

    // shared wire master
    loop_en = 0; cfg_single_wire = 1; cfg_dir_out = 1;
    @(negedge clk);
    chk(mosi_oe && !miso_oe, "R5 shared out", {mosi_oe, miso_oe}, 2'b10);
    cfg_dir_out = 0;
    @(negedge clk);
    chk(!mosi_oe && !miso_oe, "R5 shared in", {mosi_oe, miso_oe}, 2'b00);
    mosi_tb = 1; miso_tb = 0;
    n0 = rx_cnt; send(8'h00); wait_rx(n0, "R5 rx");
    chk(last_rx == 8'hFF, "R5 from mosi", last_rx, 8'hFF); wait_idle();
    mosi_tb = 0; miso_tb = 1;
    n0 = rx_cnt; send(8'hFF); wait_rx(n0, "R5 rx");
    chk(last_rx == 8'h00, "R5 miso ignored", last_rx, 8'h00); wait_idle();
    cfg_single_wire = 0;

    // mode fault
    cfg_ss_drive = 0; ss_tb = 0;
    repeat (5) @(negedge clk);
    chk(fault_flag == 1, "R8 fault set", fault_flag, 1);
    chk(!sck_oe && !mosi_oe && !miso_oe && !ss_oe && !tx_ready, "R8 released", sck_oe, 0);
    ss_tb = 1; repeat (4) @(negedge clk);
    fault_clr = 1; @(negedge clk); fault_clr = 0; @(negedge clk);
    chk(fault_flag == 0 && sck_oe, "R8 cleared", fault_flag, 0);
    cfg_fault_en = 0;

    // slave
    cfg_master = 0; miso_tb = 0;
    repeat (4) @(negedge clk);
    chk(!miso_oe && !sck_oe && !ss_oe && !mosi_oe, "R6 slave unselected", miso_oe, 0);
    send(8'hC3);
    ss_tb = 0; repeat (4) @(negedge clk);
    chk(miso_oe, "R6 slave selected", miso_oe, 1);
    n0 = rx_cnt; got = '0;
    for (int i = 7; i >= 0; i--) begin
      mosi_tb = 8'h6B >> i;
      repeat (6) @(negedge clk);
      got[i] = miso_o;
      sck_tb = 1; repeat (6) @(negedge clk);
      sck_tb = 0;
    end
    repeat (6) @(negedge clk);
    chk(got == 8'hC3, "R11 slave out", got, 8'hC3);
    chk(rx_cnt == n0 + 1 && last_rx == 8'h6B, "R11 slave in", last_rx, 8'h6B);
    cfg_single_wire = 1; cfg_dir_out = 0; @(negedge clk);
    chk(!miso_oe && !mosi_oe, "R6 shared slave input", miso_oe, 0);
    cfg_dir_out = 1; @(negedge clk);
    chk(miso_oe, "R6 shared slave output", miso_oe, 1);
    ss_tb = 1; repeat (4) @(negedge clk);
    chk(!miso_oe, "R6 shared slave unselected", miso_oe, 0);

    // disabled
    cfg_enable = 0; cfg_master = 1; @(negedge clk);
    chk(!tx_ready && !sck_oe && !mosi_oe && !miso_oe && !ss_oe, "R12 disabled", tx_ready, 0);
    finish_run();
  end
endmodule